// File: doc/BRIEF.md
# USB FIFO Byte Echo Controller

This block sits between on-chip logic and an external USB bridge device running its parallel FIFO port in the asynchronous 245-style mode. The bridge and the FPGA share no clock. The bridge reports its state on two active-low flags: one says that received bytes are waiting, the other says that there is room to transmit. The FPGA moves bytes with two active-low strobes over a single 8-bit tristate bus. The controller echoes traffic: each byte the host sends is read from the bridge, held in a one-byte register, and written back to the bridge in the same order and with the same value.

Both flags pass through two-stage synchronisers. A sequencer then produces read and write strobes whose low time, data setup, data hold and post-strobe recovery are counted in system clock cycles. Each of these counts is a parameter. The FPGA drives the bus only during a write sequence. At all other times the bus is left floating, so that the bridge can drive it during reads.

Top module: `usb_fifo_echo`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both strobes are high (inactive) and the FPGA does not drive the data bus.
- R2: A read strobe starts only when the receive-available flag has been low long enough to pass the synchroniser. Each read strobe stays low for exactly RD_LOW_CYC cycles (default 4).
- R3: The byte captured is the value on the bus during the last cycle of the read strobe, and that value is the one later written back.
- R4: Bytes are written back in the order in which they were read, with no byte lost or repeated.
- R5: At most one byte is outstanding. No new read starts until the held byte has been written back.
- R6: A write strobe starts only when the transmit-space flag has been seen low through the synchroniser. While the flag stays high, the held byte waits and no write strobe occurs.
- R7: Each write strobe stays low for exactly WR_LOW_CYC cycles (default 4). The FPGA drives the byte at least SETUP_CYC cycles before the strobe falls and at least HOLD_CYC cycles after it rises, and the value does not change anywhere in that window.
- R8: The bus is high impedance outside the write sequence, and the read and write strobes are never low at the same time.
- R9: After either strobe rises, at least RECOV_CYC cycles (default 3) pass with both strobes high before any strobe falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| fifo_data_io | inout | 8 | Shared byte bus to the bridge; driven only during writes |
| rx_avail_n_i | input | 1 | Low when the bridge holds a received byte (asynchronous) |
| tx_space_n_i | input | 1 | Low when the bridge can accept a byte (asynchronous) |
| rd_stb_n_o | output | 1 | Active-low read strobe; the bridge drives the bus while it is low |
| wr_stb_n_o | output | 1 | Active-low write strobe; the bridge takes the bus value |

## Verification
The bench holds the transmit-space flag high while bytes are pending. A design that ignored that flag would strobe a write into a full bridge, and one that kept no count of outstanding bytes would read a second byte over the first. The bench measures the low width of every strobe and the recovery gap after each one. It also records the bus value one cycle before each write strobe falls and one cycle after it rises, which catches early release or late setup of the bus driver. Bytes 00 and FF, back-to-back bursts and single trickled bytes are compared in order against a queue, so an off-by-one capture cycle or a wrong holding register shows up as a value or order mismatch.

// File: rtl/usb_fifo_echo_pkg.sv
// Package: shared types for the USB FIFO echo controller.
// Assumes: consumers import it before declaring sequencer state.
package usb_fifo_echo_pkg;

    // Sequencer phases of a read-then-write echo cycle
    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_RD_PULSE = 3'd1,
        PH_RD_RECOV = 3'd2,
        PH_WR_WAIT  = 3'd3,
        PH_WR_SETUP = 3'd4,
        PH_WR_PULSE = 3'd5,
        PH_WR_HOLD  = 3'd6,
        PH_WR_RECOV = 3'd7
    } echo_phase_e;

    // Width needed to count up to a limit value
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/usbe_sync.sv
// Module: usbe_sync
// Two-stage synchroniser for a vector of independent level signals.
// Assumes: each bit is a slow level (a flag), not a multi-bit code, so
// bits may resolve in different cycles. Flops reset to RST_VAL.
module usbe_sync #(
    parameter int unsigned W       = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic stable_q;

        // Two flops in series per bit to settle metastability
        always_ff @(posedge clk_i) begin
            if (!rst_n_i) begin
                meta_q   <= RST_VAL;
                stable_q <= RST_VAL;
            end else begin
                meta_q   <= async_i[b];
                stable_q <= meta_q;
            end
        end

        assign sync_o[b] = stable_q;
    end

endmodule

// File: rtl/usbe_hold_buf.sv
// Module: usbe_hold_buf
// One-entry byte holding register between read capture and write back.
// Assumes: load and release are never asserted in the same cycle; the
// sequencer only loads when empty and only releases when full.
module usbe_hold_buf #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              load_i,
    input  logic              release_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o
);

    logic [DATA_W-1:0] byte_q;
    logic              full_q;

    // Capture the byte on load; the value is kept until overwritten
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            byte_q <= '0;
        end else if (load_i) begin
            byte_q <= data_i;
        end
    end

    // Occupancy flag: set by load, cleared by release
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            full_q <= 1'b0;
        end else if (load_i) begin
            full_q <= 1'b1;
        end else if (release_i) begin
            full_q <= 1'b0;
        end
    end

    assign data_o = byte_q;
    assign full_o = full_q;

endmodule

// File: rtl/usbe_seq.sv
// Module: usbe_seq
// Strobe sequencer: reads one byte when the bridge has data and the
// holding register is empty, then writes it back when the bridge has
// space. Strobe low time, write setup/hold and recovery are counted.
// Assumes: flags arrive already synchronised; every count is >= 1.
// Strobes and bus enable are registered from the next phase so the pins
// change only at clock edges, without decode glitches.
module usbe_seq
    import usb_fifo_echo_pkg::*;
#(
    parameter int unsigned RD_LOW_CYC = 4,
    parameter int unsigned WR_LOW_CYC = 4,
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned HOLD_CYC   = 1,
    parameter int unsigned RECOV_CYC  = 3
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic rx_avail_n_i,
    input  logic tx_space_n_i,
    input  logic buf_full_i,
    output logic rd_stb_n_o,
    output logic wr_stb_n_o,
    output logic drv_en_o,
    output logic load_o,
    output logic release_o
);

    localparam int unsigned MAX_A   = (RD_LOW_CYC > WR_LOW_CYC) ? RD_LOW_CYC : WR_LOW_CYC;
    localparam int unsigned MAX_B   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int unsigned MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned MAX_CNT = (MAX_AB > RECOV_CYC) ? MAX_AB : RECOV_CYC;
    localparam int unsigned CW      = cnt_width(MAX_CNT);

    localparam logic [CW-1:0] RD_LAST  = CW'(RD_LOW_CYC - 1);
    localparam logic [CW-1:0] WR_LAST  = CW'(WR_LOW_CYC - 1);
    localparam logic [CW-1:0] SU_LAST  = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] HD_LAST  = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] REC_LAST = CW'(RECOV_CYC - 1);

    echo_phase_e   phase_q, phase_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          rd_n_q, wr_n_q, drv_q;
    logic          load_d, release_d;

    // Next-phase and counter decode for the echo cycle
    always_comb begin
        phase_d   = phase_q;
        cnt_d     = cnt_q + 1'b1;
        load_d    = 1'b0;
        release_d = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                cnt_d = '0;
                if (buf_full_i) begin
                    phase_d = PH_WR_WAIT;
                end else if (!rx_avail_n_i) begin
                    phase_d = PH_RD_PULSE;
                end
            end
            PH_RD_PULSE: begin
                if (cnt_q == RD_LAST) begin
                    load_d  = 1'b1;
                    phase_d = PH_RD_RECOV;
                    cnt_d   = '0;
                end
            end
            PH_RD_RECOV: begin
                if (cnt_q == REC_LAST) begin
                    phase_d = PH_WR_WAIT;
                    cnt_d   = '0;
                end
            end
            PH_WR_WAIT: begin
                cnt_d = '0;
                if (!tx_space_n_i) begin
                    phase_d = PH_WR_SETUP;
                end
            end
            PH_WR_SETUP: begin
                if (cnt_q == SU_LAST) begin
                    phase_d = PH_WR_PULSE;
                    cnt_d   = '0;
                end
            end
            PH_WR_PULSE: begin
                if (cnt_q == WR_LAST) begin
                    phase_d = PH_WR_HOLD;
                    cnt_d   = '0;
                end
            end
            PH_WR_HOLD: begin
                if (cnt_q == HD_LAST) begin
                    release_d = 1'b1;
                    phase_d   = PH_WR_RECOV;
                    cnt_d     = '0;
                end
            end
            PH_WR_RECOV: begin
                if (cnt_q == REC_LAST) begin
                    phase_d = PH_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Phase and cycle counter registers
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered pin controls taken from the next phase
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            rd_n_q <= 1'b1;
            wr_n_q <= 1'b1;
            drv_q  <= 1'b0;
        end else begin
            rd_n_q <= (phase_d != PH_RD_PULSE);
            wr_n_q <= (phase_d != PH_WR_PULSE);
            drv_q  <= (phase_d == PH_WR_SETUP) ||
                      (phase_d == PH_WR_PULSE) ||
                      (phase_d == PH_WR_HOLD);
        end
    end

    assign rd_stb_n_o = rd_n_q;
    assign wr_stb_n_o = wr_n_q;
    assign drv_en_o   = drv_q;
    assign load_o     = load_d;
    assign release_o  = release_d;

endmodule

// File: rtl/usb_fifo_echo.sv
// Module: usb_fifo_echo (top)
// Echoes every byte received from an asynchronous 245-style USB FIFO
// bridge back to it over one shared tristate byte bus.
// Assumes: the bridge flags are asynchronous to clk_i; the bridge drives
// the bus only while the read strobe is low. All timing counts >= 1.
module usb_fifo_echo #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned RD_LOW_CYC = 4,
    parameter int unsigned WR_LOW_CYC = 4,
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned HOLD_CYC   = 1,
    parameter int unsigned RECOV_CYC  = 3
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    inout  wire  [DATA_W-1:0] fifo_data_io,
    input  logic              rx_avail_n_i,
    input  logic              tx_space_n_i,
    output logic              rd_stb_n_o,
    output logic              wr_stb_n_o
);

    localparam int unsigned FLAG_W = 2;

    logic [FLAG_W-1:0] flags_sync;
    logic              buf_full;
    logic              buf_load;
    logic              buf_release;
    logic              bus_drv_en;
    logic [DATA_W-1:0] held_byte;

    usbe_sync #(
        .W       (FLAG_W),
        .RST_VAL (1'b1)
    ) flag_sync_i (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .async_i ({tx_space_n_i, rx_avail_n_i}),
        .sync_o  (flags_sync)
    );

    usbe_seq #(
        .RD_LOW_CYC (RD_LOW_CYC),
        .WR_LOW_CYC (WR_LOW_CYC),
        .SETUP_CYC  (SETUP_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .RECOV_CYC  (RECOV_CYC)
    ) seq_i (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .rx_avail_n_i (flags_sync[0]),
        .tx_space_n_i (flags_sync[1]),
        .buf_full_i   (buf_full),
        .rd_stb_n_o   (rd_stb_n_o),
        .wr_stb_n_o   (wr_stb_n_o),
        .drv_en_o     (bus_drv_en),
        .load_o       (buf_load),
        .release_o    (buf_release)
    );

    usbe_hold_buf #(
        .DATA_W (DATA_W)
    ) hold_i (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .load_i    (buf_load),
        .release_i (buf_release),
        .data_i    (fifo_data_io),
        .data_o    (held_byte),
        .full_o    (buf_full)
    );

    // Tristate driver: the held byte goes out only during a write sequence
    assign fifo_data_io = bus_drv_en ? held_byte : {DATA_W{1'bz}};

endmodule

// File: rtl/usb_fifo_echo_chk.sv
// Module: usb_fifo_echo_chk
// Protocol checker for usb_fifo_echo, attached by the bind below.
// Assumes: sampled on clk_i; strobe widths and gaps are tracked with
// saturating counters rather than deep $past windows.
module usb_fifo_echo_chk #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned RD_LOW_CYC = 4,
    parameter int unsigned WR_LOW_CYC = 4,
    parameter int unsigned RECOV_CYC  = 3
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              rd_stb_n_o,
    input logic              wr_stb_n_o,
    input logic              bus_drv_en,
    input logic [DATA_W-1:0] fifo_data_io
);

    localparam int unsigned KW = 8;
    localparam logic [KW-1:0] KMAX = '1;

    logic [KW-1:0] rd_low_cnt, wr_low_cnt, gap_cnt;
    logic          rd_q, wr_q;
    logic [1:0]    pend;

    // Track strobe low widths, idle gap and outstanding bytes
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            rd_low_cnt <= '0;
            wr_low_cnt <= '0;
            gap_cnt    <= KMAX;
            rd_q       <= 1'b1;
            wr_q       <= 1'b1;
            pend       <= '0;
        end else begin
            rd_q       <= rd_stb_n_o;
            wr_q       <= wr_stb_n_o;
            rd_low_cnt <= rd_stb_n_o ? '0 : rd_low_cnt + 1'b1;
            wr_low_cnt <= wr_stb_n_o ? '0 : wr_low_cnt + 1'b1;
            if (!rd_stb_n_o || !wr_stb_n_o) begin
                gap_cnt <= '0;
            end else if (gap_cnt != KMAX) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
            if (rd_stb_n_o && !rd_q) begin
                pend <= pend + 1'b1;
            end else if (wr_stb_n_o && !wr_q) begin
                pend <= pend - 1'b1;
            end
        end
    end

    AST_STROBES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rd_stb_n_o || wr_stb_n_o); // R8

    AST_NO_DRIVE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        bus_drv_en |-> rd_stb_n_o); // R8

    AST_RD_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(rd_stb_n_o) |-> (rd_low_cnt == KW'(RD_LOW_CYC))); // R2

    AST_WR_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(wr_stb_n_o) |-> (wr_low_cnt == KW'(WR_LOW_CYC))); // R7

    AST_WR_SETUP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(wr_stb_n_o) |-> $past(bus_drv_en)); // R7

    AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(wr_stb_n_o) |-> bus_drv_en); // R7

    AST_WR_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!wr_stb_n_o && $past(bus_drv_en)) |-> $stable(fifo_data_io)); // R7

    AST_RECOVERY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($fell(rd_stb_n_o) || $fell(wr_stb_n_o)) |-> (gap_cnt >= KW'(RECOV_CYC))); // R9

    AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(rd_stb_n_o) |-> (pend == 2'd0)); // R5

endmodule

bind usb_fifo_echo usb_fifo_echo_chk #(
    .DATA_W     (DATA_W),
    .RD_LOW_CYC (RD_LOW_CYC),
    .WR_LOW_CYC (WR_LOW_CYC),
    .RECOV_CYC  (RECOV_CYC)
) chk_i (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .rd_stb_n_o   (rd_stb_n_o),
    .wr_stb_n_o   (wr_stb_n_o),
    .bus_drv_en   (bus_drv_en),
    .fifo_data_io (fifo_data_io)
);

// File: tb/usb_fifo_echo_tb_top.sv
`timescale 1ns/1ps
// Bench: a bridge model feeds bytes in and a scoreboard compares echoes.
module usb_fifo_echo_tb_top;

    localparam int RD_LOW = 4;
    localparam int WR_LOW = 4;
    localparam int RECOV  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_avail_n = 1'b1;
    logic       tx_space_n = 1'b0;
    logic       rd_n, wr_n;
    logic [7:0] host_byte = 8'h00;
    wire  [7:0] bus_w;

    int n_chk = 0;
    int n_fail = 0;
    int n_reads = 0;
    int n_writes = 0;

    logic [7:0] host_q[$];
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    assign bus_w = (!rd_n) ? host_byte : 8'hzz;

    usb_fifo_echo dut_i (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .fifo_data_io (bus_w),
        .rx_avail_n_i (rx_avail_n),
        .tx_space_n_i (tx_space_n),
        .rd_stb_n_o   (rd_n),
        .wr_stb_n_o   (wr_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: the host sends a byte; the echo is expected in order
    task automatic send_byte(input logic [7:0] b);
        host_q.push_back(b);
        exp_q.push_back(b);
    endtask

    task automatic drain(input int limit);
        for (int i = 0; i < limit && exp_q.size() != 0; i++) @(posedge clk);
        repeat (10) @(posedge clk);
    endtask

    // Bridge model and monitor, sampling on the falling edge
    logic       prev_rd = 1'b1, prev_wr = 1'b1;
    logic [7:0] prev_bus = 8'h00;
    bit         prev_bus_z = 1'b1;
    int         rd_lo = 0, wr_lo = 0, gap = 1000, rx_hi = 0, tx_hi = 0;
    logic [7:0] wr_val = 8'h00;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!rd_n && prev_rd) begin
                chk(gap >= RECOV, "R9", "gap before read", gap, RECOV);
                chk(rx_hi < 3, "R2", "read while empty", rx_hi, 0);
                chk(n_reads == n_writes, "R5", "outstanding at read", n_reads - n_writes, 0);
                chk(wr_n === 1'b1, "R8", "write low during read", int'(wr_n), 1);
            end
            if (!wr_n && prev_wr) begin
                chk(gap >= RECOV, "R9", "gap before write", gap, RECOV);
                chk(tx_hi < 4, "R6", "write while full", tx_hi, 0);
                chk(!prev_bus_z && prev_bus === bus_w, "R7", "setup data", int'(prev_bus), int'(bus_w));
                wr_val = bus_w;
            end
            if (!wr_n && !prev_wr) begin
                chk(bus_w === wr_val, "R7", "data stable in strobe", int'(bus_w), int'(wr_val));
            end
            if (rd_n && !prev_rd) begin
                chk(rd_lo == RD_LOW, "R2", "read strobe width", rd_lo, RD_LOW);
                void'(host_q.pop_front());
                n_reads++;
            end
            if (wr_n && !prev_wr) begin
                chk(wr_lo == WR_LOW, "R7", "write strobe width", wr_lo, WR_LOW);
                chk(bus_w === wr_val, "R7", "hold data", int'(bus_w), int'(wr_val));
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected echo", int'(bus_w), 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(bus_w === e, "R3", "echoed value/order R4", int'(bus_w), int'(e));
                end
                n_writes++;
            end
        end
        rd_lo = rd_n ? 0 : rd_lo + 1;
        wr_lo = wr_n ? 0 : wr_lo + 1;
        gap   = (rd_n && wr_n) ? ((gap < 1000) ? gap + 1 : gap) : 0;
        rx_hi = rx_avail_n ? rx_hi + 1 : 0;
        tx_hi = tx_space_n ? tx_hi + 1 : 0;
        prev_rd    = rd_n;
        prev_wr    = wr_n;
        prev_bus   = bus_w;
        prev_bus_z = (bus_w === 8'hzz);
        rx_avail_n = (host_q.size() == 0);
        host_byte  = (host_q.size() != 0) ? host_q[0] : 8'h00;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w0;
        int r0;
        repeat (4) @(posedge clk);
        #1;
        chk(rd_n === 1'b1, "R1", "read strobe in reset", int'(rd_n), 1);
        chk(wr_n === 1'b1, "R1", "write strobe in reset", int'(wr_n), 1);
        chk(bus_w === 8'hzz, "R1", "bus released in reset", int'(bus_w), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(rd_n === 1'b1 && wr_n === 1'b1, "R1", "strobes after reset", int'({rd_n, wr_n}), 3);
        repeat (20) @(posedge clk); #1;
        chk(rd_n === 1'b1 && n_reads == 0, "R2", "no read while empty", n_reads, 0);
        chk(bus_w === 8'hzz, "R8", "bus idle release", int'(bus_w), 0);

        // Single byte
        send_byte(8'hA5);
        drain(2000);
        chk(n_writes == 1, "R4", "single echo count", n_writes, 1);

        // Burst with boundary values
        send_byte(8'h00); send_byte(8'hFF); send_byte(8'h5A);
        send_byte(8'h01); send_byte(8'h80); send_byte(8'h7E);
        drain(5000);
        chk(n_writes == 7, "R4", "burst echo count", n_writes, 7);

        // Transmit blocked: one byte held, no write, no second read
        @(posedge clk); #1;
        tx_space_n = 1'b1;
        w0 = n_writes;
        r0 = n_reads;
        send_byte(8'h3C); send_byte(8'hC3); send_byte(8'h99);
        repeat (80) @(posedge clk); #1;
        chk(n_writes == w0, "R6", "no write while full", n_writes - w0, 0);
        chk(n_reads == r0 + 1, "R5", "single read while blocked", n_reads - r0, 1);
        tx_space_n = 1'b0;
        drain(5000);
        chk(n_writes == w0 + 3, "R6", "blocked bytes released", n_writes - w0, 3);

        // Trickle with tx space toggling
        for (int i = 0; i < 8; i++) begin
            send_byte(8'(i * 37 + 11));
            repeat (3 + i) @(posedge clk); #1;
            tx_space_n = i[0];
            repeat (5) @(posedge clk); #1;
            tx_space_n = 1'b0;
        end
        drain(5000);
        chk(exp_q.size() == 0, "R4", "all trickle bytes echoed", exp_q.size(), 0);
        chk(n_reads == n_writes, "R5", "reads equal writes", n_reads, n_writes);
        repeat (5) @(posedge clk); #1;
        chk(bus_w === 8'hzz && rd_n && wr_n, "R8", "final bus release", int'(bus_w), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule